// File: doc/BRIEF.md
# Dual-Channel Frame CRC Checker

This block checks the 24-bit frame checksum of a serial automotive-bus frame. A framing stage ahead of it has already removed start sequences and byte separators. It hands over only the clean frame bits, most significant bit first, one bit per cycle in which the bit-valid strobe is high. A start-of-frame pulse seeds the shift register. The seed depends on which of the two bus channels the frame came in on, so the same frame gives a different checksum on each channel.

Every bit between the start-of-frame pulse and the payload-done marker is covered. That is the 40-bit header followed by the payload bytes, which may be none. After the marker, the next 24 valid bits are the received trailer. Once the last trailer bit is in, the block raises a one-cycle done pulse. At the same time it presents a match flag, which stays put until the next frame begins. The running checksum is always visible for debug.

Top module: `frame_crc_checker`

## Requirements
- R1: After reset, `crc_done_o` and `crc_ok_o` are 0 and `crc_val_o` is 0.
- R2: The cycle after `sof_i` is sampled high, `crc_val_o` holds the seed. The seed is 0xFEDCBA when `chan_sel_i` was 0 (channel A) at that edge and 0xABCDEF when it was 1 (channel B).
- R3: Each covered bit updates the register as follows. Let f be bit 23 of the register XOR the data bit. The register shifts left by one with a 0 entering bit 0, and is then XORed with 0x5D6DCB if f is 1. No final inversion or XOR is applied.
- R4: Between `sof_i` and `pay_done_i`, only cycles with `bit_vld_i` high advance the register. Idle cycles leave `crc_val_o` unchanged.
- R5: A change of `chan_sel_i` after the start-of-frame pulse has no effect on the frame in progress.
- R6: After `pay_done_i`, the next 24 valid bits are taken as the trailer, most significant bit first. They do not change `crc_val_o`.
- R7: `crc_done_o` is high for exactly one cycle: the cycle after the edge that samples the 24th trailer bit.
- R8: `crc_ok_o` rises together with `crc_done_o` exactly when the received trailer equals `crc_val_o`. It stays at that value until the next `sof_i`, which clears it.
- R9: A frame with an empty payload (40 header bits, then `pay_done_i`) is checked the same way as any other frame.
- R10: After the check completes and before the next `sof_i`, further valid bits and markers change neither `crc_val_o` nor `crc_ok_o`, and raise no second done pulse.
- R11: A `sof_i` in the middle of a frame abandons that frame and starts a new one with the seed of the channel selected at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel_i | input | 1 | Channel select sampled at start of frame: 0 = A, 1 = B |
| sof_i | input | 1 | Start-of-frame pulse, loads the seed |
| bit_vld_i | input | 1 | Strobe: `bit_i` carries a frame bit this cycle |
| bit_i | input | 1 | Serial frame bit, MSB first |
| pay_done_i | input | 1 | Marker after the last payload bit; trailer bits follow |
| crc_done_o | output | 1 | One-cycle pulse when the trailer comparison is complete |
| crc_ok_o | output | 1 | Trailer matched the computed checksum |
| crc_val_o | output | 24 | Running checksum register, for debug |

## Verification
Every result of this block appears one edge after the input that causes it. The seed is visible in the cycle after the start pulse. Each covered bit moves `crc_val_o` in the cycle after it is strobed. Done and match appear in the cycle after the 24th trailer bit. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge that samples them. It compares all three outputs on the next falling edge. So every comparison, including the named checks after a frame, is made one full register stage after its stimulus.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BODY  = 2'd1,
        PH_TRAIL = 2'd2,
        PH_END   = 2'd3
    } phase_e;

endpackage

// File: rtl/crc_lfsr_step.sv
module crc_lfsr_step #(
    parameter int               WIDTH = 24,
    parameter logic [WIDTH-1:0] POLY  = 24'h5D6DCB
) (
    input  logic [WIDTH-1:0] crc_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] crc_o
);
    logic fb;

    always_comb begin
        fb    = crc_i[WIDTH-1] ^ bit_i;
        crc_o = {crc_i[WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

endmodule

// File: rtl/crc_seed_sel.sv
module crc_seed_sel #(
    parameter int               WIDTH  = 24,
    parameter logic [WIDTH-1:0] SEED_A = 24'hFEDCBA,
    parameter logic [WIDTH-1:0] SEED_B = 24'hABCDEF
) (
    input  logic             chan_b_i,
    output logic [WIDTH-1:0] seed_o
);
    always_comb begin
        seed_o = chan_b_i ? SEED_B : SEED_A;
    end

endmodule

// File: rtl/trailer_shift.sv
module trailer_shift #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] cand_o,
    output logic             last_o
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [WIDTH-2:0] word;
        logic [CNT_W-1:0] cnt;
    } trl_t;

    trl_t tr_d, tr_q;

    always_comb begin
        tr_d = tr_q;
        if (clr_i) begin
            tr_d.word = '0;
            tr_d.cnt  = '0;
        end else if (shift_i) begin
            tr_d.word = {tr_q.word[WIDTH-3:0], bit_i};
            tr_d.cnt  = tr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tr_q <= '0;
        else        tr_q <= tr_d;
    end

    assign cand_o = {tr_q.word, bit_i};
    assign last_o = (tr_q.cnt == CNT_W'(WIDTH - 1));

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tr_q.cnt <= CNT_W'(WIDTH)); // R6

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tr_q.cnt == '0)); // R11

endmodule

// File: rtl/frame_crc_checker.sv
module frame_crc_checker #(
    parameter int                CRC_W  = 24,
    parameter logic [CRC_W-1:0]  POLY   = 24'h5D6DCB,
    parameter logic [CRC_W-1:0]  SEED_A = 24'hFEDCBA,
    parameter logic [CRC_W-1:0]  SEED_B = 24'hABCDEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_sel_i,
    input  logic             sof_i,
    input  logic             bit_vld_i,
    input  logic             bit_i,
    input  logic             pay_done_i,
    output logic             crc_done_o,
    output logic             crc_ok_o,
    output logic [CRC_W-1:0] crc_val_o
);
    import fcrc_pkg::*;

    typedef struct packed {
        phase_e           phase;
        logic [CRC_W-1:0] crc;
        logic             done;
        logic             ok;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] trl_cand;
    logic             trl_last;
    logic             trl_shift;

    crc_lfsr_step #(.WIDTH(CRC_W), .POLY(POLY)) u_step (
        .crc_i (st_q.crc),
        .bit_i (bit_i),
        .crc_o (crc_next)
    );

    crc_seed_sel #(.WIDTH(CRC_W), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_seed (
        .chan_b_i (chan_sel_i),
        .seed_o   (seed)
    );

    assign trl_shift = (st_q.phase == PH_TRAIL) && bit_vld_i && !sof_i;

    trailer_shift #(.WIDTH(CRC_W)) u_trl (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (sof_i),
        .shift_i (trl_shift),
        .bit_i   (bit_i),
        .cand_o  (trl_cand),
        .last_o  (trl_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (sof_i) begin
            st_d.phase = PH_BODY;
            st_d.crc   = seed;
            st_d.ok    = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_BODY: begin
                    if (bit_vld_i)  st_d.crc   = crc_next;
                    if (pay_done_i) st_d.phase = PH_TRAIL;
                end
                PH_TRAIL: begin
                    if (bit_vld_i && trl_last) begin
                        st_d.phase = PH_END;
                        st_d.done  = 1'b1;
                        st_d.ok    = (trl_cand == st_q.crc);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, crc: '0, done: 1'b0, ok: 1'b0};
        else        st_q <= st_d;
    end

    assign crc_done_o = st_q.done;
    assign crc_ok_o   = st_q.ok;
    assign crc_val_o  = st_q.crc;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sof_i |=> (crc_val_o == ($past(chan_sel_i) ? SEED_B : SEED_A))); // R2

    AST_BODY_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_BODY && !bit_vld_i && !sof_i) |=> $stable(crc_val_o)); // R4

    AST_TRAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TRAIL && !sof_i) |=> $stable(crc_val_o)); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done_o |=> !crc_done_o); // R7

    AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_ok_o) |-> crc_done_o); // R8

    AST_END_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_END && !sof_i) |=> ($stable(crc_ok_o) && $stable(crc_val_o) && !crc_done_o)); // R10

endmodule

// File: tb/sim_frame_crc_checker.sv
module sim_frame_crc_checker;
    localparam logic [23:0] POLY  = 24'h5D6DCB;
    localparam logic [23:0] SD_A  = 24'hFEDCBA;
    localparam logic [23:0] SD_B  = 24'hABCDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_sel_i = 1'b0, sof_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, pay_done_i = 1'b0;
    logic crc_done_o, crc_ok_o;
    logic [23:0] crc_val_o;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    frame_crc_checker u0 (
        .clk(clk), .rst_n(rst_n), .chan_sel_i(chan_sel_i), .sof_i(sof_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .pay_done_i(pay_done_i),
        .crc_done_o(crc_done_o), .crc_ok_o(crc_ok_o), .crc_val_o(crc_val_o)
    );

    function automatic logic [23:0] step(logic [23:0] c, logic b);
        logic f;
        f = c[23] ^ b;
        step = {c[22:0], 1'b0};
        if (f) step = step ^ POLY;
    endfunction

    function automatic logic [23:0] ref_crc(logic [23:0] seed, bit q[$]);
        logic [23:0] c;
        c = seed;
        foreach (q[i]) c = step(c, q[i]);
        return c;
    endfunction

    function automatic logic nxt_bit();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng[0];
    endfunction

    // behavioural reference: phase 0 idle, 1 body, 2 trailer, 3 finished
    int          m_phase = 0;
    int          m_tcnt  = 0;
    logic [23:0] m_crc   = '0;
    logic [23:0] m_tword = '0;
    logic        m_done  = 1'b0;
    logic        m_ok    = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_tcnt = 0; m_crc = '0; m_tword = '0; m_done = 0; m_ok = 0;
        end else begin
            m_done = 1'b0;
            if (sof_i) begin
                m_phase = 1; m_crc = chan_sel_i ? SD_B : SD_A; m_ok = 0; m_tcnt = 0; m_tword = '0;
            end else if (m_phase == 1) begin
                if (bit_vld_i) m_crc = step(m_crc, bit_i);
                if (pay_done_i) m_phase = 2;
            end else if (m_phase == 2 && bit_vld_i) begin
                m_tword = {m_tword[22:0], bit_i};
                m_tcnt++;
                if (m_tcnt == 24) begin
                    m_phase = 3; m_done = 1'b1; m_ok = (m_tword == m_crc);
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 crc_val", 32'(crc_val_o), 32'(m_crc));
            chk("R7 crc_done", 32'(crc_done_o), 32'(m_done));
            chk("R8 crc_ok", 32'(crc_ok_o), 32'(m_ok));
        end
    end

    task automatic drive(logic s, logic ch, logic v, logic b, logic pd);
        @(negedge clk);
        sof_i = s; chan_sel_i = ch; bit_vld_i = v; bit_i = b; pay_done_i = pd;
    endtask

    task automatic idle_cycle();
        drive(1'b0, chan_sel_i, 1'b0, 1'b0, 1'b0);
    endtask

    // sends one frame; returns the computed checksum
    task automatic send_frame(logic ch, int nbytes, logic [23:0] corrupt, bit gaps,
                              bit flip, output logic [23:0] exp_crc);
        bit q[$];
        logic [23:0] trl;
        for (int i = 0; i < 40 + 8 * nbytes; i++) q.push_back(nxt_bit());
        exp_crc = ref_crc(ch ? SD_B : SD_A, q);
        trl = exp_crc ^ corrupt;
        drive(1'b1, ch, 1'b0, 1'b0, 1'b0);
        drive(1'b0, flip ? ~ch : ch, 1'b0, 1'b0, 1'b0);
        chk("R2 seed", 32'(crc_val_o), 32'(ch ? SD_B : SD_A));
        foreach (q[i]) begin
            drive(1'b0, flip ? ~ch : ch, 1'b1, q[i], 1'b0);
            if (gaps && q[i]) idle_cycle();
        end
        drive(1'b0, ch, 1'b0, 1'b0, 1'b1);
        for (int i = 23; i >= 0; i--) begin
            drive(1'b0, ch, 1'b1, trl[i], 1'b0);
            if (gaps && i == 12) idle_cycle();
        end
        idle_cycle();
        chk("R7 done after 24th trailer bit", 32'(crc_done_o), 32'd1);
        chk("R6 value unchanged by trailer", 32'(crc_val_o), 32'(exp_crc));
        chk("R8 match flag", 32'(crc_ok_o), 32'(corrupt == 0));
        idle_cycle();
        chk("R7 done is one cycle", 32'(crc_done_o), 32'd0);
        chk("R8 match held", 32'(crc_ok_o), 32'(corrupt == 0));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [23:0] ca, cb, tmp;
        repeat (3) @(negedge clk);
        chk("R1 done after reset", 32'(crc_done_o), 32'd0);
        chk("R1 ok after reset", 32'(crc_ok_o), 32'd0);
        chk("R1 value after reset", 32'(crc_val_o), 32'd0);
        rst_n = 1'b1;

        rng = 32'hCAFE_0001;
        send_frame(1'b0, 4, 24'h0, 0, 0, ca);      // R3 channel A
        rng = 32'hCAFE_0001;
        send_frame(1'b1, 4, 24'h0, 0, 0, cb);      // R3 same frame on channel B
        chk("R2 channels differ", 32'(ca != cb), 32'd1);
        send_frame(1'b0, 3, 24'h000100, 0, 0, tmp); // R8 corrupted trailer
        send_frame(1'b1, 2, 24'h800000, 0, 0, tmp); // R8 corrupted MSB
        send_frame(1'b0, 0, 24'h0, 0, 0, tmp);      // R9 empty payload
        send_frame(1'b1, 0, 24'h000001, 0, 0, tmp); // R9 empty payload, mismatch
        send_frame(1'b1, 5, 24'h0, 1, 0, tmp);      // R4 gaps in strobe
        send_frame(1'b0, 6, 24'h0, 0, 1, tmp);      // R5 channel flips mid-frame

        // R10: stray bits and markers after completion
        for (int i = 0; i < 12; i++) drive(1'b0, 1'b0, 1'b1, nxt_bit(), i == 5);
        idle_cycle();
        chk("R10 value frozen", 32'(crc_val_o), 32'(tmp));
        chk("R10 ok frozen", 32'(crc_ok_o), 32'd1);
        chk("R10 no second done", 32'(crc_done_o), 32'd0);

        // R11: abandon a frame midway
        drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, 1'b1, nxt_bit(), 1'b0);
        chk("R8 ok cleared by sof", 32'(crc_ok_o), 32'd0);
        send_frame(1'b1, 1, 24'h0, 0, 0, tmp);      // R11 restart on channel B
        for (int i = 0; i < 30; i++) send_frame(i[0], i % 7, (i % 3 == 0) ? 24'(i + 1) : 24'h0, i[1], i[2], tmp);
        repeat (4) idle_cycle();
        finish_run();
    end

endmodule